// File: doc/BRIEF.md
# Rational Resize Phase Sequencer

This block turns a reduced scaling ratio `num/denom` into the list of phase entries that fills one axis of a resize coefficient table. Each entry pairs a phase weight with a source advance. The weight runs from 0 to 512, where 512 puts the whole weight on the current source pixel. The advance is the number of source pixels to step before the next output pixel. A pulse on `start` latches the ratio. The block then presents exactly `num` entries on a valid/ready output port, one per handshake, and flags the final one with `out_last`.

Which rule the block follows depends on the ratio. A shrinking ratio (`denom > num`) walks a doubled-resolution phase accumulator that starts at `denom`. A whole-number enlargement (`denom == 1`) uses plain pixel repetition and advances the source only on the final entry. Any other enlargement walks an accumulator that starts at zero and advances by at most one pixel per entry. The block never approximates: every weight and every advance comes from exact integer division. A shared multi-cycle restoring divider does the division, and the output port stays idle while a division is in progress.

A 1:1 ratio needs no table, so the block reports completion without emitting anything. The block rejects a ratio it cannot encode: a table longer than 31 entries, a zero numerator or a zero denominator.

Top module: `rsz_phase_seq`

## Requirements
- R1: After an accepted `start` with `num` in 1..31, `denom` ≥ 1 and a ratio other than 1:1, exactly `num` entries are transferred, one on each cycle where `out_valid` and `out_ready` are both high. `out_last` is high on the `num`-th entry and low on all others. After reset, `out_valid`, `done` and `err` are low.
- R2: Shrink rule when `denom > num`. Whole-number enlargement rule when `denom == 1` and `num > 1`. Fractional enlargement rule in all remaining cases, including unreduced ratios such as 2/2.
- R3: Fractional enlargement. An accumulator `a` starts at 0. For each entry, weight = 512 − floor(512·a/num). Then `a` grows by `denom`. The advance is 1 if `a ≥ num`, and in that case `num` is subtracted from `a`. Otherwise the advance is 0.
- R4: Whole-number enlargement. Every entry has weight 512. The advance is 1 on the last entry and 0 on every earlier entry.
- R5: Shrink. An accumulator `a` starts at `denom`. For each entry, `a` becomes num + ((a − num) mod 2·num). The weight is 512 − floor(512·(a − num)/(2·num)). Then `a` grows by 2·denom, and the advance is floor((a − num)/(2·num)).
- R6: A 1:1 ratio produces no entries. `done` is high for one cycle, in the cycle after `start` is sampled.
- R7: A ratio with `num` = 0, `num` > 31 or `denom` = 0 produces no entries and no `done`. `err` is high for one cycle, in the cycle after `start` is sampled.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_weight`, `out_offset` and `out_last` hold their values.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the last entry, and it is never high while a table is still being produced.
- R10: A `start` pulse that arrives while a table is being produced is ignored. The current table finishes unchanged, and no second table follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch `num`/`denom` and begin a table (sampled only when idle) |
| num | input | NUM_W (6) | Ratio numerator, the table length |
| denom | input | DEN_W (8) | Ratio denominator |
| out_ready | input | 1 | Consumer accepts the presented entry |
| out_valid | output | 1 | An entry is presented |
| out_weight | output | 10 | Phase weight, 0..512 |
| out_offset | output | DEN_W (8) | Source pixels to advance after this entry |
| out_last | output | 1 | Presented entry is the final one |
| done | output | 1 | One-cycle pulse: table finished (or 1:1 ratio) |
| err | output | 1 | One-cycle pulse: ratio rejected |

## Verification
The bench sweeps every table length from 1 to 31 against denominators of 1, 2, 3, 7, 19 and 255. These cover the whole-number rule, fractional enlargement with small and coprime steps, and shrink ratios from mild to extreme, where the advance reaches 255. An unreduced 2/2 ratio checks that equal terms fall to the fractional rule and not the 1:1 bypass. The consumer holds back `out_ready` in a fixed pattern, which shows that entries are held and not skipped or repeated. Single-shot runs cover the 1:1, zero and oversize ratios, and a run with a stray `start` pulse partway through shows that the current table is not disturbed.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  // Full weight: every share on the current source pixel.
  localparam int unsigned WT_W    = 10;
  localparam int unsigned WT_FULL = 512;
  localparam int unsigned WT_LOG2 = 9;

  typedef enum logic [1:0] {
    MODE_FRAC = 2'd0,
    MODE_INT  = 2'd1,
    MODE_DOWN = 2'd2,
    MODE_NONE = 2'd3
  } rsz_mode_e;

  // Rule choice for a ratio n/d; operands are zero-extended by the caller.
  function automatic rsz_mode_e f_pick_mode(input logic [15:0] n, input logic [15:0] d);
    if (n == 16'd1 && d == 16'd1) return MODE_NONE;
    if (d > n)                    return MODE_DOWN;
    if (d == 16'd1)               return MODE_INT;
    return MODE_FRAC;
  endfunction

  // Weight from the scaled phase quotient q = floor(512*phase/divisor).
  function automatic logic [WT_W-1:0] f_weight(input logic [WT_W-1:0] q);
    return WT_W'(WT_FULL) - q;
  endfunction

endpackage

// File: rtl/rsz_restoring_div.sv
module rsz_restoring_div #(
  parameter int NW   = 15,
  parameter int DV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NW-1:0]   dividend,
  input  logic [DV_W-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [NW-1:0]   quot,
  output logic [DV_W-1:0] rem
);
  localparam int CW = $clog2(NW);

  logic [NW-1:0]   q_r;
  logic [DV_W-1:0] r_r, d_r;
  logic [CW-1:0]   cnt_r;
  logic            busy_r, done_r;

  // One quotient bit per cycle: shift in the next dividend bit, try to subtract.
  logic [DV_W:0] shifted;
  logic [DV_W:0] nxt_rem;
  logic          fits;

  assign shifted = {r_r, q_r[NW-1]};
  assign fits    = (shifted >= {1'b0, d_r});
  assign nxt_rem = fits ? (shifted - {1'b0, d_r}) : shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        q_r    <= dividend;
        r_r    <= '0;
        d_r    <= divisor;
        cnt_r  <= '0;
        busy_r <= 1'b1;
      end else if (busy_r) begin
        r_r   <= nxt_rem[DV_W-1:0];
        q_r   <= {q_r[NW-2:0], fits};
        cnt_r <= cnt_r + 1'b1;
        if (cnt_r == CW'(NW - 1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r;

  // Partial remainder never reaches the divisor (R5 arithmetic relies on it).
  p_partial_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> (nxt_rem < {1'b0, d_r}));

  // Final remainder is a proper residue.
  p_final_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (r_r < d_r));

  // The sequencer only launches a division when the unit is free (R10).
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_r);

endmodule

// File: rtl/rsz_ratio_decode.sv
module rsz_ratio_decode
  import rsz_pkg::*;
#(
  parameter int NUM_W    = 6,
  parameter int DEN_W    = 8,
  parameter int MAX_TAPS = 31,
  parameter int TAP_W    = 5,
  parameter int DV_W     = 6
) (
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] denom,
  output logic             bad,
  output rsz_mode_e        mode,
  output logic [TAP_W-1:0] taps,
  output logic [DV_W-1:0]  divisor,
  output logic [DEN_W:0]   step,
  output logic [DEN_W-1:0] seed
);
  logic is_down;

  assign bad     = (num == '0) || (num > NUM_W'(MAX_TAPS)) || (denom == '0);
  assign mode    = f_pick_mode(16'(num), 16'(denom));
  assign is_down = (mode == MODE_DOWN);
  assign taps    = num[TAP_W-1:0];

  // The shrink rule works at twice the phase resolution.
  assign divisor = is_down ? {taps, 1'b0} : {1'b0, taps};
  assign step    = is_down ? {denom, 1'b0} : {1'b0, denom};
  assign seed    = is_down ? (denom - DEN_W'(taps)) : '0;

endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
  import rsz_pkg::*;
#(
  parameter int MAX_TAPS = 31,
  parameter int NUM_W    = 6,
  parameter int DEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] denom,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [9:0]       out_weight,
  output logic [DEN_W-1:0] out_offset,
  output logic             out_last,
  output logic             done,
  output logic             err
);
  localparam int TAP_W = $clog2(MAX_TAPS + 1);
  localparam int DV_W  = TAP_W + 1;
  localparam int NW_A  = DV_W + WT_LOG2;
  localparam int NW_B  = DEN_W + 2;
  localparam int NW    = (NW_A > NW_B) ? NW_A : NW_B;

  typedef enum logic [2:0] {S_IDLE, S_SEED, S_WDIV, S_ODIV, S_EMIT} seq_state_e;

  seq_state_e       state_q;
  rsz_mode_e        mode_q;
  logic [TAP_W-1:0] taps_q, idx_q;
  logic [DV_W-1:0]  div_q, rem_q;
  logic [DEN_W:0]   step_q;
  logic [WT_W-1:0]  weight_q;
  logic [DEN_W-1:0] offset_q;
  logic             done_q, err_q;

  // Decoded ratio
  logic             dec_bad;
  rsz_mode_e        dec_mode;
  logic [TAP_W-1:0] dec_taps;
  logic [DV_W-1:0]  dec_div;
  logic [DEN_W:0]   dec_step;
  logic [DEN_W-1:0] dec_seed;

  rsz_ratio_decode #(
    .NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W), .DV_W(DV_W)
  ) decode_i (
    .num(num), .denom(denom), .bad(dec_bad), .mode(dec_mode),
    .taps(dec_taps), .divisor(dec_div), .step(dec_step), .seed(dec_seed)
  );

  // Named internal events
  logic accept_start, handshake, is_last, launch_seq;
  logic             dv_start, dv_busy, dv_done;
  logic [NW-1:0]    dv_dividend, dv_quot;
  logic [DV_W-1:0]  dv_divisor, dv_rem;

  assign accept_start = start && (state_q == S_IDLE);
  assign is_last      = (idx_q == taps_q - TAP_W'(1));
  assign handshake    = out_valid && out_ready;
  assign launch_seq   = accept_start && !dec_bad &&
                        (dec_mode == MODE_FRAC || dec_mode == MODE_DOWN);

  // Divider launch points: seed reduction, weight quotient, advance quotient.
  always_comb begin
    dv_start    = 1'b0;
    dv_dividend = '0;
    dv_divisor  = div_q;
    unique case (state_q)
      S_IDLE: begin
        dv_start    = launch_seq;
        dv_dividend = NW'(dec_seed);
        dv_divisor  = dec_div;
      end
      S_SEED: begin
        dv_start    = dv_done;
        dv_dividend = NW'({dv_rem, {WT_LOG2{1'b0}}});
      end
      S_WDIV: begin
        dv_start    = dv_done;
        dv_dividend = NW'(rem_q) + NW'(step_q);
      end
      S_EMIT: begin
        dv_start    = handshake && !is_last && (mode_q != MODE_INT);
        dv_dividend = NW'({rem_q, {WT_LOG2{1'b0}}});
      end
      default: ;
    endcase
  end

  rsz_restoring_div #(.NW(NW), .DV_W(DV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(dv_start),
    .dividend(dv_dividend), .divisor(dv_divisor),
    .busy(dv_busy), .done(dv_done), .quot(dv_quot), .rem(dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mode_q   <= MODE_NONE;
      taps_q   <= '0;
      idx_q    <= '0;
      div_q    <= '0;
      rem_q    <= '0;
      step_q   <= '0;
      weight_q <= '0;
      offset_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          if (dec_bad) begin
            err_q <= 1'b1;
          end else if (dec_mode == MODE_NONE) begin
            done_q <= 1'b1;
          end else begin
            mode_q <= dec_mode;
            taps_q <= dec_taps;
            div_q  <= dec_div;
            step_q <= dec_step;
            idx_q  <= '0;
            if (dec_mode == MODE_INT) begin
              weight_q <= WT_W'(WT_FULL);
              offset_q <= '0;
              state_q  <= S_EMIT;
            end else begin
              state_q <= S_SEED;
            end
          end
        end
        S_SEED: if (dv_done) begin
          rem_q   <= dv_rem;
          state_q <= S_WDIV;
        end
        S_WDIV: if (dv_done) begin
          weight_q <= f_weight(dv_quot[WT_W-1:0]);
          state_q  <= S_ODIV;
        end
        S_ODIV: if (dv_done) begin
          offset_q <= dv_quot[DEN_W-1:0];
          rem_q    <= dv_rem;
          state_q  <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          if (is_last) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (mode_q == MODE_INT) begin
              offset_q <= DEN_W'((idx_q + 1'b1) == (taps_q - TAP_W'(1)));
            end else begin
              state_q <= S_WDIV;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign out_valid  = (state_q == S_EMIT);
  assign out_weight = weight_q;
  assign out_offset = offset_q;
  assign out_last   = is_last;
  assign done       = done_q;
  assign err        = err_q;

  // ---- assertions ----
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_weight) &&
                                   $stable(out_offset) && $stable(out_last)));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && out_last) |=> (done && !out_valid));

  p_no_early_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !out_last) |=> !done);

  p_weight_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_weight != '0 && out_weight <= 10'd512));

  p_int_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == MODE_INT) |-> (out_weight == 10'd512));

  p_frac_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == MODE_FRAC) |-> (out_offset <= DEN_W'(1)));

  p_wquot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_done && state_q == S_WDIV) |-> (dv_quot < NW'(WT_FULL)));

  p_oquot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_done && state_q == S_ODIV) |-> (dv_quot < NW'(1 << DEN_W)));

  p_err_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !out_valid));

  p_quiet_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dv_busy |-> !out_valid);

endmodule

// File: tb/rsz_phase_seq_tb.sv
module rsz_phase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [5:0] num;
  logic [7:0] denom;
  logic       out_ready;
  logic       out_valid;
  logic [9:0] out_weight;
  logic [7:0] out_offset;
  logic       out_last;
  logic       done;
  logic       err;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rsz_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num(num), .denom(denom),
    .out_ready(out_ready), .out_valid(out_valid), .out_weight(out_weight),
    .out_offset(out_offset), .out_last(out_last), .done(done), .err(err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One full table for n/d; when poke is set a stray start arrives mid-run.
  task automatic run_ratio(input int n, input int d, input bit poke);
    int  acc, ew, eo, got, cyc, pw, po, pl;
    bit  down, intg, fin, stall_prev, rdy;
    string tag;
    down = (d > n);
    intg = (d == 1);
    acc  = down ? d : 0;
    tag  = intg ? "R4" : (down ? "R5" : "R3");
    @(negedge clk);
    num = 6'(n); denom = 8'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0; fin = 1'b0; stall_prev = 1'b0; pw = 0; po = 0; pl = 0;
    while (!fin && cyc < 6000) begin
      if (poke && cyc == 20) begin
        num = 6'd5; denom = 8'd3; start = 1'b1;   // R10 stray start
      end else begin
        start = 1'b0;
      end
      rdy = ((cyc % 5) != 2);
      out_ready = rdy;
      if (stall_prev) begin
        check("R8", "valid held", int'(out_valid), 1);
        check("R8", "weight held", int'(out_weight), pw);
        check("R8", "offset held", int'(out_offset), po);
        check("R8", "last held", int'(out_last), pl);
      end
      if (done) check("R9", "done before last entry", 1, 0);
      if (err)  check("R7", "err during valid table", 1, 0);
      if (out_valid && rdy) begin
        if (intg) begin
          ew = 512; eo = (got == n - 1) ? 1 : 0;
        end else if (down) begin
          acc = n + (acc - n) % (2 * n);
          ew  = 512 - (512 * (acc - n)) / (2 * n);
          acc = acc + 2 * d;
          eo  = (acc - n) / (2 * n);
        end else begin
          ew  = 512 - (512 * acc) / n;
          acc = acc + d;
          eo  = (acc >= n) ? 1 : 0;
          if (eo == 1) acc = acc - n;
        end
        check(tag, $sformatf("R2 weight n=%0d d=%0d i=%0d", n, d, got), int'(out_weight), ew);
        check(tag, $sformatf("R2 offset n=%0d d=%0d i=%0d", n, d, got), int'(out_offset), eo);
        check("R1", $sformatf("last n=%0d d=%0d i=%0d", n, d, got), int'(out_last),
              (got == n - 1) ? 1 : 0);
        got++;
        if (out_last || got >= n) fin = 1'b1;
      end
      stall_prev = out_valid && !rdy;
      pw = int'(out_weight); po = int'(out_offset); pl = int'(out_last);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    check("R1", $sformatf("entry count n=%0d d=%0d", n, d), got, n);
    check("R9", "done after last", int'(done), 1);
    check("R9", "valid low after last", int'(out_valid), 0);
    @(negedge clk);
    check("R9", "done single cycle", int'(done), 0);
  endtask

  // Start that must not produce a table: err or done one cycle later.
  task automatic run_single(input int n, input int d, input bit exp_err, input string req);
    bit any_valid, extra;
    @(negedge clk);
    num = 6'(n); denom = 8'(d); start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, $sformatf("err n=%0d d=%0d", n, d), int'(err), exp_err ? 1 : 0);
    check(req, $sformatf("done n=%0d d=%0d", n, d), int'(done), exp_err ? 0 : 1);
    any_valid = 1'b0; extra = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_valid) any_valid = 1'b1;
      if (done || err) extra = 1'b1;
    end
    check(req, "no entries", int'(any_valid), 0);
    check(req, "no further pulses", int'(extra), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit any_valid;
    int dens [6] = '{1, 2, 3, 7, 19, 255};
    rst_n = 1'b0; start = 1'b0; num = '0; denom = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset valid", int'(out_valid), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset err", int'(err), 0);
    rst_n = 1'b1;

    run_single(1, 1, 1'b0, "R6");
    run_single(0, 5, 1'b1, "R7");
    run_single(32, 3, 1'b1, "R7");
    run_single(40, 1, 1'b1, "R7");
    run_single(4, 0, 1'b1, "R7");

    run_ratio(2, 2, 1'b0);   // unreduced: fractional rule (R2)

    // R10: stray start while busy; table must finish as n=9 d=4 and stop.
    run_ratio(9, 4, 1'b1);
    any_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (out_valid || done) any_valid = 1'b1;
    end
    check("R10", "no second table after stray start", int'(any_valid), 0);

    foreach (dens[j]) begin
      for (int n = 1; n <= 31; n++) begin
        if (!(n == 1 && dens[j] == 1)) run_ratio(n, dens[j], 1'b0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule